// File: doc/BRIEF.md
# Multichannel Converter Capture Buffer

This block sits between a multichannel converter receive path and a stream that feeds a DMA engine. On each valid beat of the converter device clock it takes one sample from every channel that the enable mask selects and writes those samples into one shared block memory. A start request freezes the mask and begins a capture. The block then divides the memory evenly among the selected channels, so a capture with fewer channels runs deeper per channel. Once the capture has run for its computed number of beats, further beats are dropped.

A second, independent clock drains the stored samples onto a valid/ready stream. Samples come out one per handshake, interleaved by channel, and the final sample of each capture is flagged. The two clock domains exchange progress through gray-coded beat counters. A start request that arrives while the previous capture is still being taken or drained is refused, and the refusal is reported on a sticky overflow output.

Top module: `adc_capture_buffer`

## Requirements
- R1: After reset the stream output is idle (`m_valid` low) and `ctl_overflow` is low.
- R2: An accepted `ctl_start` stores exactly D beats, taken from the next D cycles with `adc_valid` high. Beats that arrive after the D-th are not stored and never appear on the stream.
- R3: With n channels enabled (n = popcount of the mask) and a total capacity of NUM_CH*CH_DEPTH samples, D is that capacity divided by n and rounded down to a power of two. One enabled channel gives D = NUM_CH*CH_DEPTH. All channels enabled gives D = CH_DEPTH. With the defaults, three channels give D = 64. A capture therefore delivers n*D samples.
- R4: The stream delivers beats in arrival order. Within a beat it delivers the samples of the enabled channels in ascending channel index, with one SAMPLE_W-bit sample per handshake. Channel c occupies `adc_data[c*SAMPLE_W +: SAMPLE_W]`.
- R5: `m_last` is high on the n*D-th sample of a capture and low on every other sample.
- R6: Changes to `ctl_enable` after a capture has been accepted do not change which channels that capture stores.
- R7: A `ctl_start` with a nonzero mask that arrives while a capture is running, or while the previous capture still holds samples beyond the one presented on the stream, is refused and does not restart or alter the capture. It sets `ctl_overflow`, which stays high until the next accepted start clears it.
- R8: A `ctl_start` with an all-zero mask is ignored. No capture starts and `ctl_overflow` keeps its value.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` hold their values.
- R10: Cycles with `adc_valid` low store nothing and do not count toward D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Converter device clock (capture side) |
| wr_rst | input | 1 | Synchronous active-high reset, capture side |
| ctl_enable | input | NUM_CH | Channel enable mask, sampled at an accepted start |
| ctl_start | input | 1 | One-cycle capture request |
| ctl_overflow | output | 1 | Sticky flag for a refused start request |
| adc_valid | input | 1 | Converter beat valid |
| adc_data | input | NUM_CH*SAMPLE_W | One sample per channel, channel 0 in the low bits |
| rd_clk | input | 1 | Drain-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, drain side |
| m_valid | output | 1 | Stream sample valid |
| m_ready | input | 1 | Stream sink ready |
| m_data | output | SAMPLE_W | Stream sample |
| m_last | output | 1 | Final sample of the capture |

## Verification
A wrong rank or bank computation on the capture side shows up as an out-of-order or foreign sample. This happens on the first stream beat that reads the corrupted location, a few drain cycles after that beat crosses the clock boundary. A wrong depth or a wrong last-beat count appears either as a misplaced `m_last` or as extra samples on the stream, at the end of the affected capture. A drain-state check that errs in either direction shows up as a missing or spurious overflow flag one capture-clock cycle after the request, or else as a restarted capture whose data no longer matches.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

   // Smallest r with 2**r >= v (0 for v <= 1).
   function automatic int ceil_log2(input int v);
      int r;
      r = 0;
      for (int i = 0; i < 16; i++) begin
         if ((1 << i) < v) r = i + 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/capbuf_bank.sv
module capbuf_bank #(
   parameter int W    = 16,
   parameter int ROWS = 64,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [RW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rd_clk,
   input  logic          re,
   input  logic [RW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [ROWS];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk) begin
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/capbuf_gray_sync.sv
module capbuf_gray_sync #(
   parameter int PW          = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          src_clk,
   input  logic          src_rst,
   input  logic [PW-1:0] src_bin,
   input  logic          dst_clk,
   input  logic          dst_rst,
   output logic [PW-1:0] dst_bin
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "capbuf_gray_sync: SYNC_STAGES must be at least 2");
   end

   logic [PW-1:0] src_gray;
   logic [SYNC_STAGES-1:0][PW-1:0] stage;

   always_ff @(posedge src_clk) begin
      if (src_rst) src_gray <= '0;
      else         src_gray <= src_bin ^ (src_bin >> 1);
   end

   always_ff @(posedge dst_clk) begin
      if (dst_rst) stage <= '0;
      else begin
         stage[0] <= src_gray;
         for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      end
   end

   always_comb begin
      dst_bin[PW-1] = stage[SYNC_STAGES-1][PW-1];
      for (int i = PW - 2; i >= 0; i--) begin
         dst_bin[i] = dst_bin[i+1] ^ stage[SYNC_STAGES-1][i];
      end
   end

endmodule

// File: rtl/capbuf_wr_ctrl.sv
module capbuf_wr_ctrl #(
   parameter int NUM_CH   = 4,
   parameter int CH_DEPTH = 64,
   parameter int SAMPLE_W = 16,
   localparam int TOTAL   = NUM_CH * CH_DEPTH,
   localparam int TL      = $clog2(TOTAL),
   localparam int BL      = $clog2(NUM_CH),
   localparam int RW      = $clog2(CH_DEPTH),
   localparam int PW      = TL + 1,
   localparam int CW      = $clog2(NUM_CH + 1),
   localparam int DW      = $clog2(TL + 1)
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               start,
   input  logic [NUM_CH-1:0]                  en_mask,
   input  logic                               in_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]         in_data,
   input  logic [PW-1:0]                      rd_beat,
   output logic [PW-1:0]                      wr_beat,
   output logic [CW-1:0]                      cfg_n,
   output logic [DW-1:0]                      cfg_dlog,
   output logic                               overflow,
   output logic [NUM_CH-1:0]                  bank_we,
   output logic [NUM_CH-1:0][RW-1:0]          bank_row,
   output logic [NUM_CH-1:0][SAMPLE_W-1:0]    bank_din
);

   logic              capturing;
   logic [NUM_CH-1:0] cap_mask;
   logic [TL-1:0]     lbeat;
   logic [TL-1:0]     last_beat;
   logic [TL-1:0]     base;
   logic [NUM_CH-1:0][TL-1:0] lin;
   logic              take;
   logic              drained;

   assign last_beat = TL'((32'd1 << cfg_dlog) - 32'd1);
   assign base      = lbeat * TL'(cfg_n);
   assign take      = capturing && in_valid;
   assign drained   = (rd_beat == wr_beat);

   // Linear address of each enabled channel's sample in this beat:
   // beat base plus the channel's rank among enabled channels.
   always_comb begin
      logic [TL-1:0] acc;
      acc = base;
      for (int c = 0; c < NUM_CH; c++) begin
         lin[c] = acc;
         if (cap_mask[c]) acc = acc + TL'(1);
      end
   end

   // Low address bits pick the bank, so one beat never hits a bank twice.
   always_comb begin
      bank_we  = '0;
      bank_row = '0;
      bank_din = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (take && cap_mask[c]) begin
            bank_we [lin[c][BL-1:0]] = 1'b1;
            bank_row[lin[c][BL-1:0]] = lin[c][TL-1:BL];
            bank_din[lin[c][BL-1:0]] = in_data[c*SAMPLE_W +: SAMPLE_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         capturing <= 1'b0;
         cap_mask  <= '0;
         cfg_n     <= CW'(1);
         cfg_dlog  <= DW'(TL);
         lbeat     <= '0;
         wr_beat   <= '0;
         overflow  <= 1'b0;
      end else begin
         if (take) begin
            wr_beat <= wr_beat + PW'(1);
            lbeat   <= lbeat + TL'(1);
            if (lbeat == last_beat) capturing <= 1'b0;
         end
         if (start && en_mask != '0) begin
            if (capturing || !drained) begin
               overflow <= 1'b1;
            end else begin
               capturing <= 1'b1;
               cap_mask  <= en_mask;
               cfg_n     <= CW'($countones(en_mask));
               cfg_dlog  <= DW'(TL - capbuf_pkg::ceil_log2($countones(en_mask)));
               lbeat     <= '0;
               overflow  <= 1'b0;
            end
         end
      end
   end

   a_r1_wr_reset_clear: assert property (@(posedge clk) rst |=> !overflow);

   a_r7_overflow_needs_start: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow) |-> $past(start));

   a_r8_empty_mask_no_capture: assert property (@(posedge clk) disable iff (rst)
      (start && en_mask == '0 && !capturing) |=> (!capturing && $stable(overflow)));

   a_r2_beat_within_depth: assert property (@(posedge clk) disable iff (rst)
      capturing |-> (lbeat <= last_beat));

   a_r6_mask_frozen: assert property (@(posedge clk) disable iff (rst)
      (capturing && $past(capturing)) |-> $stable(cap_mask));

   a_r10_idle_no_advance: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !start) |=> $stable(wr_beat));

endmodule

// File: rtl/capbuf_rd_ctrl.sv
module capbuf_rd_ctrl #(
   parameter int NUM_CH   = 4,
   parameter int CH_DEPTH = 64,
   localparam int TOTAL   = NUM_CH * CH_DEPTH,
   localparam int TL      = $clog2(TOTAL),
   localparam int BL      = $clog2(NUM_CH),
   localparam int RW      = $clog2(CH_DEPTH),
   localparam int PW      = TL + 1,
   localparam int CW      = $clog2(NUM_CH + 1),
   localparam int DW      = $clog2(TL + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PW-1:0]     wr_beat,
   input  logic [CW-1:0]     cfg_n,
   input  logic [DW-1:0]     cfg_dlog,
   input  logic              out_ready,
   output logic [PW-1:0]     rd_beat,
   output logic [NUM_CH-1:0] bank_re,
   output logic [RW-1:0]     bank_row,
   output logic [BL-1:0]     sel,
   output logic              out_valid,
   output logic              out_last
);

   logic [TL-1:0] raddr;
   logic [CW-1:0] rank;
   logic [TL-1:0] lbeat;
   logic [TL-1:0] last_beat;
   logic          issue;
   logic          end_beat;
   logic          end_cap;

   assign last_beat = TL'((32'd1 << cfg_dlog) - 32'd1);
   assign issue     = (rd_beat != wr_beat) && (!out_valid || out_ready);
   assign end_beat  = (rank == cfg_n - CW'(1));
   assign end_cap   = end_beat && (lbeat == last_beat);
   assign bank_re   = issue ? (NUM_CH'(1) << raddr[BL-1:0]) : '0;
   assign bank_row  = raddr[TL-1:BL];

   always_ff @(posedge clk) begin
      if (rst) begin
         raddr     <= '0;
         rank      <= '0;
         lbeat     <= '0;
         rd_beat   <= '0;
         sel       <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else if (issue) begin
         out_valid <= 1'b1;
         out_last  <= end_cap;
         sel       <= raddr[BL-1:0];
         raddr     <= end_cap ? '0 : raddr + TL'(1);
         if (end_beat) begin
            rank    <= '0;
            rd_beat <= rd_beat + PW'(1);
            lbeat   <= end_cap ? '0 : lbeat + TL'(1);
         end else begin
            rank    <= rank + CW'(1);
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end
   end

   a_r4_no_overread: assert property (@(posedge clk) disable iff (rst)
      PW'(wr_beat - rd_beat) <= PW'(TOTAL));

   a_r5_last_closes_capture: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_last) |-> (raddr == '0 && rank == '0));

endmodule

// File: rtl/adc_capture_buffer.sv
module adc_capture_buffer #(
   parameter int NUM_CH      = 4,
   parameter int CH_DEPTH    = 64,
   parameter int SAMPLE_W    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int TOTAL      = NUM_CH * CH_DEPTH,
   localparam int TL         = $clog2(TOTAL),
   localparam int BL         = $clog2(NUM_CH),
   localparam int RW         = $clog2(CH_DEPTH),
   localparam int PW         = TL + 1,
   localparam int CW         = $clog2(NUM_CH + 1),
   localparam int DW         = $clog2(TL + 1)
) (
   input  logic                         wr_clk,
   input  logic                         wr_rst,
   input  logic [NUM_CH-1:0]            ctl_enable,
   input  logic                         ctl_start,
   output logic                         ctl_overflow,
   input  logic                         adc_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]   adc_data,
   input  logic                         rd_clk,
   input  logic                         rd_rst,
   output logic                         m_valid,
   input  logic                         m_ready,
   output logic [SAMPLE_W-1:0]          m_data,
   output logic                         m_last
);

   if (NUM_CH < 2 || (1 << BL) != NUM_CH) begin : g_bad_num_ch
      initial $fatal(1, "adc_capture_buffer: NUM_CH must be a power of two >= 2");
   end
   if (CH_DEPTH < 2 || (1 << RW) != CH_DEPTH) begin : g_bad_depth
      initial $fatal(1, "adc_capture_buffer: CH_DEPTH must be a power of two >= 2");
   end

   logic [PW-1:0] wr_beat, wr_beat_rd;
   logic [PW-1:0] rd_beat, rd_beat_wr;
   logic [CW-1:0] cfg_n;
   logic [DW-1:0] cfg_dlog;
   logic [NUM_CH-1:0]                wr_we;
   logic [NUM_CH-1:0][RW-1:0]        wr_row;
   logic [NUM_CH-1:0][SAMPLE_W-1:0]  wr_din;
   logic [NUM_CH-1:0]                rd_re;
   logic [RW-1:0]                    rd_row;
   logic [BL-1:0]                    rd_sel;
   logic [NUM_CH-1:0][SAMPLE_W-1:0]  bank_q;

   capbuf_wr_ctrl #(.NUM_CH(NUM_CH), .CH_DEPTH(CH_DEPTH), .SAMPLE_W(SAMPLE_W)) u_wr (
      .clk(wr_clk), .rst(wr_rst), .start(ctl_start), .en_mask(ctl_enable),
      .in_valid(adc_valid), .in_data(adc_data), .rd_beat(rd_beat_wr),
      .wr_beat(wr_beat), .cfg_n(cfg_n), .cfg_dlog(cfg_dlog), .overflow(ctl_overflow),
      .bank_we(wr_we), .bank_row(wr_row), .bank_din(wr_din)
   );

   capbuf_gray_sync #(.PW(PW), .SYNC_STAGES(SYNC_STAGES)) u_sync_w2r (
      .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_beat),
      .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(wr_beat_rd)
   );

   capbuf_gray_sync #(.PW(PW), .SYNC_STAGES(SYNC_STAGES)) u_sync_r2w (
      .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_beat),
      .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rd_beat_wr)
   );

   capbuf_rd_ctrl #(.NUM_CH(NUM_CH), .CH_DEPTH(CH_DEPTH)) u_rd (
      .clk(rd_clk), .rst(rd_rst), .wr_beat(wr_beat_rd), .cfg_n(cfg_n),
      .cfg_dlog(cfg_dlog), .out_ready(m_ready), .rd_beat(rd_beat),
      .bank_re(rd_re), .bank_row(rd_row), .sel(rd_sel),
      .out_valid(m_valid), .out_last(m_last)
   );

   for (genvar b = 0; b < NUM_CH; b++) begin : g_bank
      capbuf_bank #(.W(SAMPLE_W), .ROWS(CH_DEPTH)) u_bank (
         .wr_clk(wr_clk), .we(wr_we[b]), .waddr(wr_row[b]), .wdata(wr_din[b]),
         .rd_clk(rd_clk), .re(rd_re[b]), .raddr(rd_row), .rdata(bank_q[b])
      );
   end

   assign m_data = bank_q[rd_sel];

   a_r1_rd_reset_idle: assert property (@(posedge rd_clk) rd_rst |=> !m_valid);

   a_r9_hold_under_backpressure: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

endmodule

// File: tb/adc_capture_buffer_bench.sv
module adc_capture_buffer_bench;

   localparam int NCH = 4;
   localparam int CHD = 64;
   localparam int SW  = 16;

   typedef struct packed {
      logic [SW-1:0] d;
      logic          l;
   } item_t;

   logic              wr_clk = 1'b0;
   logic              rd_clk = 1'b0;
   logic              wr_rst = 1'b1;
   logic              rd_rst = 1'b1;
   logic [NCH-1:0]    ctl_enable = '0;
   logic              ctl_start = 1'b0;
   logic              ctl_overflow;
   logic              adc_valid = 1'b0;
   logic [NCH*SW-1:0] adc_data = '0;
   logic              m_valid;
   logic              m_ready = 1'b0;
   logic [SW-1:0]     m_data;
   logic              m_last;

   item_t exp_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   int    got_cnt = 0;
   int    exp_total = 0;
   int    rdy_mode = 0;
   string cur_tag = "R4";

   always #2 wr_clk = ~wr_clk;   // 250 MHz
   always #3 rd_clk = ~rd_clk;

   adc_capture_buffer u_adc_capture_buffer (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .ctl_enable(ctl_enable), .ctl_start(ctl_start),
      .ctl_overflow(ctl_overflow), .adc_valid(adc_valid), .adc_data(adc_data),
      .rd_clk(rd_clk), .rd_rst(rd_rst), .m_valid(m_valid), .m_ready(m_ready),
      .m_data(m_data), .m_last(m_last)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops and compares on the negative edge of the drain clock.
   initial begin : p_monitor
      logic [15:0]   lfsr;
      bit            hold_pend;
      logic [SW-1:0] hold_d;
      logic          hold_l;
      item_t         e;
      lfsr = 16'hACE1;
      hold_pend = 1'b0;
      forever begin
         @(negedge rd_clk);
         if (hold_pend) begin
            n_cmp++;
            if (!(m_valid && m_data == hold_d && m_last == hold_l)) begin
               n_bad++;
               $display("FAIL R9 held beat changed: actual v=%b d=%h l=%b expected v=1 d=%h l=%b",
                        m_valid, m_data, m_last, hold_d, hold_l);
            end
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (rdy_mode)
            0:       m_ready = 1'b1;
            1:       m_ready = lfsr[0];
            default: m_ready = 1'b0;
         endcase
         hold_pend = m_valid && !m_ready;
         hold_d    = m_data;
         hold_l    = m_last;
         if (m_valid && m_ready && !rd_rst) begin
            if (exp_q.size() == 0) begin
               n_cmp++;
               n_bad++;
               $display("FAIL R2 unexpected sample actual=%h expected=none", m_data);
            end else begin
               e = exp_q.pop_front();
               got_cnt++;
               n_cmp++;
               if (m_data != e.d) begin
                  n_bad++;
                  $display("FAIL %s sample data actual=%h expected=%h", cur_tag, m_data, e.d);
               end
               n_cmp++;
               if (m_last != e.l) begin
                  n_bad++;
                  $display("FAIL R5 last flag actual=%b expected=%b (data %h)", m_last, e.l, e.d);
               end
            end
         end
      end
   end

   task automatic run_capture(input logic [NCH-1:0] mask, input logic [3:0] tag,
                              input bit gaps, input logic [NCH-1:0] mid_mask,
                              input int restart_at, input int extra);
      int n, lg, d, k;
      item_t it;
      n  = $countones(mask);
      lg = 0;
      while ((1 << lg) < n) lg++;
      d  = (NCH * CHD) >> lg;           // R3 depth rule
      exp_total = n * d;
      got_cnt   = 0;
      @(posedge wr_clk); #1;
      ctl_enable = mask;
      ctl_start  = 1'b1;
      @(posedge wr_clk); #1;
      ctl_start  = 1'b0;
      for (int b = 0; b < d + extra; b++) begin
         if (gaps && (b % 3 == 1)) begin   // R10 idle cycle with junk data
            adc_valid = 1'b0;
            adc_data  = {16'hBAD3, 16'hBAD2, 16'hBAD1, 16'hBAD0};
            @(posedge wr_clk); #1;
         end
         adc_valid = 1'b1;
         k = 0;
         for (int c = 0; c < NCH; c++) begin
            adc_data[c*SW +: SW] = (b < d) ? {tag, 2'(c), 10'(b)} : {4'hF, 2'(c), 10'(b)};
            if (b < d && mask[c]) begin
               it.d = {tag, 2'(c), 10'(b)};
               it.l = (b == d - 1) && (k == n - 1);
               exp_q.push_back(it);
               k++;
            end
         end
         ctl_start = (b == restart_at);
         if (b == d / 2) ctl_enable = mid_mask;
         @(posedge wr_clk); #1;
      end
      adc_valid = 1'b0;
      ctl_start = 1'b0;
   endtask

   task automatic wait_drain(input string req);
      int t;
      t = 0;
      while (exp_q.size() != 0 && t < 40000) begin
         @(posedge rd_clk);
         t++;
      end
      repeat (30) @(posedge rd_clk);
      #1;
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      check(got_cnt == exp_total, "R3", got_cnt, exp_total);
   endtask

   task automatic pulse_start(input logic [NCH-1:0] mask);
      @(posedge wr_clk); #1;
      ctl_enable = mask;
      ctl_start  = 1'b1;
      @(posedge wr_clk); #1;
      ctl_start  = 1'b0;
      @(posedge wr_clk); #1;
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge wr_clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : p_main
      repeat (10) @(posedge rd_clk);
      wr_rst = 1'b0;
      rd_rst = 1'b0;
      @(negedge wr_clk);
      check(m_valid == 1'b0, "R1", m_valid, 0);
      check(ctl_overflow == 1'b0, "R1", ctl_overflow, 0);

      // All channels: CH_DEPTH beats each (R3, R4)
      rdy_mode = 0; cur_tag = "R4";
      run_capture(4'b1111, 4'h1, 1'b0, 4'b1111, -1, 4);
      wait_drain("R2");

      // Single channel takes the whole memory, random backpressure (R3, R9)
      rdy_mode = 1;
      run_capture(4'b0001, 4'h2, 1'b0, 4'b0001, -1, 3);
      wait_drain("R3");

      // Three channels round down to 64 beats, idle cycles in between (R10)
      cur_tag = "R10";
      run_capture(4'b1011, 4'h3, 1'b1, 4'b1011, -1, 2);
      wait_drain("R10");

      // Mask changed mid-capture must not matter (R6)
      cur_tag = "R6";
      run_capture(4'b0101, 4'h4, 1'b0, 4'b1010, -1, 2);
      wait_drain("R6");

      // Start during a running capture is refused and flagged (R7)
      cur_tag = "R7";
      run_capture(4'b1100, 4'h5, 1'b0, 4'b1100, 10, 0);
      @(negedge wr_clk);
      check(ctl_overflow == 1'b1, "R7", ctl_overflow, 1);
      wait_drain("R7");

      // Zero-mask start ignored, flag kept (R8)
      pulse_start(4'b0000);
      repeat (40) @(posedge rd_clk);
      @(negedge wr_clk);
      check(ctl_overflow == 1'b1, "R8", ctl_overflow, 1);
      check(m_valid == 1'b0, "R8", m_valid, 0);

      // Accepted start clears the flag (R7)
      rdy_mode = 0; cur_tag = "R4";
      run_capture(4'b1000, 4'h6, 1'b0, 4'b1000, -1, 0);
      @(negedge wr_clk);
      check(ctl_overflow == 1'b0, "R7", ctl_overflow, 0);
      wait_drain("R4");

      // Start while the previous capture is not yet drained (R7)
      rdy_mode = 2; cur_tag = "R7";
      run_capture(4'b1111, 4'h7, 1'b0, 4'b1111, -1, 0);
      repeat (30) @(posedge wr_clk);
      pulse_start(4'b0001);
      @(negedge wr_clk);
      check(ctl_overflow == 1'b1, "R7", ctl_overflow, 1);
      rdy_mode = 0;
      wait_drain("R7");

      // Next accepted capture clears it again; two channels give 128 beats
      rdy_mode = 1; cur_tag = "R4";
      run_capture(4'b0011, 4'h8, 1'b1, 4'b0110, -1, 2);
      @(negedge wr_clk);
      check(ctl_overflow == 1'b0, "R7", ctl_overflow, 0);
      wait_drain("R5");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule